// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block adds a second calendar alarm to a real-time clock and uses it to shut the system down. Software programs a target date and time as six BCD bytes and arms a power-control bit. When the calendar core signals a seconds update and the running time equals the target in every field, the block raises a sticky alarm flag and can raise an interrupt. If power control is armed, the same match also drives the power-enable output low, so an external regulator removes the main supply.

The calendar counter is not part of this block. It supplies the current BCD time as one 48-bit word together with a one-cycle pulse that marks each seconds update. Registers are reached through a simple word-addressed port with byte strobes and a read data port that is one register deep.

Top module: `rtc_pwroff_ctrl`

## Requirements
- R1: After a synchronous reset, `pwr_en_o` is 1, `irq_o` is 0, and every register reads 0: the six target bytes, the status flag, the interrupt enable and the power-control bit.
- R2: The target bytes sit at 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year) in bits 7:0. A write updates a byte only when strobe bit 0 is set. A read returns the byte on `reg_rdata` one clock after `reg_rd`.
- R3: The power-control bit is bit 16 of the word at 0x98. It is written when strobe bit 2 is set and reads back in the same position.
- R4: The alarm interrupt enable is bit 4 of the word at 0x48. It changes only on a write with all four strobes set. Any partial write leaves it unchanged.
- R5: On a clock edge where `sec_tick` is 1 and all six target bytes equal the matching bytes of `time_now`, the status flag (bit 7 of 0x44) is 1 after that edge. Equal values without `sec_tick` do not set it.
- R6: If any single field differs, a seconds update leaves the status flag at 0.
- R7: Writing 0x44 with strobe bit 0 set and data bit 7 set clears the flag. Writing a 0 in bit 7 leaves it set.
- R8: When a match and a clearing write fall on the same edge, the flag ends up set.
- R9: After every edge, `irq_o` equals the status flag ANDed with the interrupt enable.
- R10: A match while the power-control bit is 1 drives `pwr_en_o` to 0 on the same edge that sets the flag. It then stays 0 until reset, even if the control bit or the flag is cleared.
- R11: A match while the power-control bit is 0 sets only the flag (and the interrupt, if enabled). `pwr_en_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write strobes |
| reg_rdata | output | 32 | Read data, registered |
| sec_tick | input | 1 | One-cycle seconds-update pulse from the calendar |
| time_now | input | 48 | Current BCD time {year, month, day, hour, min, sec} |
| irq_o | output | 1 | Alarm interrupt, registered |
| pwr_en_o | output | 1 | Power-enable output, 1 = supply on |

## Verification
The collision that matters is a seconds update that produces a match on the same edge as software's write-one-to-clear of the status flag. The bench drives both in one cycle and then reads the flag back. It must still be set, because losing that event would also hide the power-off that came with it. A second overlap is a full-word write to the interrupt enable while the flag is already set. `irq_o` is judged directly after that edge, with no extra cycle allowed.

// File: rtl/rtc_pwroff_pkg.sv
package rtc_pwroff_pkg;
  localparam int FIELD_W   = 8;
  localparam int NFIELD    = 6;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int TGT_BASE  = 32'h80;
  localparam int TGT_STEP  = 4;
  localparam int PCTL_OFS  = 32'h98;
  localparam int STS_OFS   = 32'h44;
  localparam int IEN_OFS   = 32'h48;
  localparam int PCTL_BIT  = 16;
  localparam int IEN_BIT   = 4;
  localparam int STS_BIT   = 7;

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2,
    F_DAY = 3'd3, F_MON = 3'd4, F_YEAR = 3'd5
  } field_e;
endpackage

// File: rtl/rtc_a2_regs.sv
module rtc_a2_regs
  import rtc_pwroff_pkg::*;
#(
  parameter int NF  = NFIELD,
  parameter int FW  = FIELD_W,
  parameter int AW  = ADDR_W,
  parameter int SW  = DATA_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [FW-1:0]    wbyte,
  input  logic             wbit_pctl,
  input  logic             wbit_ien,
  input  logic [SW-1:0]    wstrb,
  output logic [NF*FW-1:0] target_o,
  output logic             pctl_o,
  output logic             ien_o,
  output logic             ien_d_o
);
  localparam int PCTL_LANE = PCTL_BIT / 8;

  logic pctl_q, ien_q;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_tgt
      logic [FW-1:0] byte_q;
      logic          hit;
      assign hit = wr && wstrb[0] && (addr == AW'(TGT_BASE + TGT_STEP * i));
      always_ff @(posedge clk) begin
        if (rst)      byte_q <= '0;
        else if (hit) byte_q <= wbyte;
      end
      assign target_o[i*FW +: FW] = byte_q;
    end
  endgenerate

  always_comb begin
    ien_d_o = ien_q;
    if (wr && (wstrb == {SW{1'b1}}) && (addr == AW'(IEN_OFS)))
      ien_d_o = wbit_ien;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pctl_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      ien_q <= ien_d_o;
      if (wr && wstrb[PCTL_LANE] && (addr == AW'(PCTL_OFS)))
        pctl_q <= wbit_pctl;
    end
  end

  assign pctl_o = pctl_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/rtc_a2_match.sv
module rtc_a2_match
  import rtc_pwroff_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int FW = FIELD_W
) (
  input  logic             tick,
  input  logic [NF*FW-1:0] target,
  input  logic [NF*FW-1:0] now,
  output logic             hit_o
);
  logic [NF-1:0] eq;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_cmp
      assign eq[i] = (target[i*FW +: FW] == now[i*FW +: FW]);
    end
  endgenerate

  assign hit_o = tick && (&eq);
endmodule

// File: rtl/rtc_a2_pwr.sv
module rtc_a2_pwr (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic pctl,
  input  logic ien_d,
  output logic sts_o,
  output logic irq_o,
  output logic pwr_en_o
);
  logic sts_q, sts_d, irq_q, pwr_q;

  assign sts_d = hit | (sts_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
      pwr_q <= 1'b1;
    end else begin
      sts_q <= sts_d;
      irq_q <= sts_d & ien_d;
      if (hit && pctl) pwr_q <= 1'b0;
    end
  end

  assign sts_o    = sts_q;
  assign irq_o    = irq_q;
  assign pwr_en_o = pwr_q;
endmodule

// File: rtl/rtc_pwroff_ctrl.sv
module rtc_pwroff_ctrl
  import rtc_pwroff_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int FW = FIELD_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [DW/8-1:0]  reg_wstrb,
  output logic [DW-1:0]    reg_rdata,
  input  logic             sec_tick,
  input  logic [NF*FW-1:0] time_now,
  output logic             irq_o,
  output logic             pwr_en_o
);
  localparam int SW = DW / 8;

  logic [NF*FW-1:0] target;
  logic             ctrl_q, ien_q, ien_d, sts_q, hit, clr;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  rtc_a2_regs #(.NF(NF), .FW(FW), .AW(AW), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
    .wbyte(reg_wdata[FW-1:0]), .wbit_pctl(reg_wdata[PCTL_BIT]),
    .wbit_ien(reg_wdata[IEN_BIT]), .wstrb(reg_wstrb),
    .target_o(target), .pctl_o(ctrl_q), .ien_o(ien_q), .ien_d_o(ien_d)
  );

  rtc_a2_match #(.NF(NF), .FW(FW)) u_match (
    .tick(sec_tick), .target(target), .now(time_now), .hit_o(hit)
  );

  assign clr = reg_wr && reg_wstrb[STS_BIT/8] && reg_wdata[STS_BIT] &&
               (reg_addr == AW'(STS_OFS));

  rtc_a2_pwr u_pwr (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .pctl(ctrl_q),
    .ien_d(ien_d), .sts_o(sts_q), .irq_o(irq_o), .pwr_en_o(pwr_en_o)
  );

  always_comb begin
    rdata_d = '0;
    if (reg_addr == AW'(STS_OFS))  rdata_d[STS_BIT]  = sts_q;
    if (reg_addr == AW'(IEN_OFS))  rdata_d[IEN_BIT]  = ien_q;
    if (reg_addr == AW'(PCTL_OFS)) rdata_d[PCTL_BIT] = ctrl_q;
    for (int i = 0; i < NF; i++)
      if (reg_addr == AW'(TGT_BASE + TGT_STEP * i))
        rdata_d[FW-1:0] = target[i*FW +: FW];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/rtc_pwroff_chk.sv
module rtc_pwroff_chk (
  input logic clk,
  input logic rst,
  input logic sec_tick,
  input logic irq_o,
  input logic pwr_en_o,
  input logic sts,
  input logic ien,
  input logic ctrl
);
  // R10: once off, the power enable never returns without reset
  p_pwr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !pwr_en_o |=> !pwr_en_o);

  // R10: power goes off only together with a raised flag
  p_pwr_with_flag_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en_o) |-> sts);

  // R11: power-off needs the control bit armed in the matching cycle
  p_pwr_needs_ctrl_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en_o) |-> $past(ctrl));

  // R5: the flag only rises after a seconds update
  p_flag_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sts) |-> $past(sec_tick));

  // R9: interrupt tracks flag and enable
  p_irq_track_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (sts && ien));
endmodule

bind rtc_pwroff_ctrl rtc_pwroff_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .irq_o(irq_o),
  .pwr_en_o(pwr_en_o), .sts(sts_q), .ien(ien_q), .ctrl(ctrl_q)
);

// File: tb/rtc_pwroff_ctrl_tb.sv
module rtc_pwroff_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, sec_tick = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, rdv;
  logic [3:0]  reg_wstrb = '0;
  logic [31:0] reg_rdata;
  logic [47:0] time_now = '0;
  logic        irq_o, pwr_en_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  rtc_pwroff_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb),
    .reg_rdata(reg_rdata), .sec_tick(sec_tick), .time_now(time_now),
    .irq_o(irq_o), .pwr_en_o(pwr_en_o)
  );

  // {expected match, target {yr,mo,dy,hr,mi,se}, time}
  localparam logic [96:0] VEC [8] = '{
    {1'b1, 48'h99_12_31_23_30_59, 48'h99_12_31_23_30_59},
    {1'b0, 48'h99_12_31_23_30_58, 48'h99_12_31_23_30_59},
    {1'b0, 48'h99_12_31_23_31_59, 48'h99_12_31_23_30_59},
    {1'b0, 48'h99_12_31_22_30_59, 48'h99_12_31_23_30_59},
    {1'b0, 48'h99_12_30_23_30_59, 48'h99_12_31_23_30_59},
    {1'b0, 48'h99_11_31_23_30_59, 48'h99_12_31_23_30_59},
    {1'b0, 48'h98_12_31_23_30_59, 48'h99_12_31_23_30_59},
    {1'b1, 48'h25_02_28_07_45_01, 48'h25_02_28_07_45_01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
    @(negedge clk); reg_wr = 0; reg_wstrb = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic load_target(input logic [47:0] t);
    for (int f = 0; f < 6; f++) wr(8'h80 + 8'(4 * f), {24'h0, t[f*8 +: 8]}, 4'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] al, tm;
    logic        e;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 pwr_en", {31'b0, pwr_en_o}, 32'h1);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(8'h44, rdv); check("R1 status", rdv, 32'h0);
    rd(8'h48, rdv); check("R1 ien", rdv, 32'h0);
    rd(8'h98, rdv); check("R1 pctl", rdv, 32'h0);
    rd(8'h94, rdv); check("R1 year byte", rdv, 32'h0);

    // R5/R6 table walk, control off
    for (int v = 0; v < 8; v++) begin
      {e, al, tm} = VEC[v];
      load_target(al);
      time_now = tm;
      tick();
      rd(8'h44, rdv);
      check(e ? "R5 match" : "R6 mismatch", rdv, e ? 32'h80 : 32'h0);
      check("R11 pwr stays on", {31'b0, pwr_en_o}, 32'h1);
      if (e) wr(8'h44, 32'h80, 4'h1);
    end

    // R2 readback and strobe gating
    rd(8'h80, rdv); check("R2 sec", rdv, 32'h01);
    rd(8'h88, rdv); check("R2 hour", rdv, 32'h07);
    rd(8'h90, rdv); check("R2 month", rdv, 32'h02);
    wr(8'h80, 32'h11, 4'h2);
    rd(8'h80, rdv); check("R2 lane0 strobe", rdv, 32'h01);

    // R5 equal without tick
    repeat (3) @(negedge clk);
    rd(8'h44, rdv); check("R5 no tick", rdv, 32'h0);

    // R4 partial write ignored, full write taken
    wr(8'h48, 32'h10, 4'h1);
    rd(8'h48, rdv); check("R4 partial", rdv, 32'h0);
    wr(8'h48, 32'h10, 4'hF);
    rd(8'h48, rdv); check("R4 full", rdv, 32'h10);

    // R9 interrupt follows flag
    tick();
    check("R9 irq set", {31'b0, irq_o}, 32'h1);
    // R7 writing zero keeps flag
    wr(8'h44, 32'h00, 4'h1);
    rd(8'h44, rdv); check("R7 zero write", rdv, 32'h80);
    wr(8'h44, 32'h80, 4'h1);
    check("R9 irq cleared", {31'b0, irq_o}, 32'h0);
    rd(8'h44, rdv); check("R7 cleared", rdv, 32'h0);

    // R8 match and clear on the same edge
    @(negedge clk);
    sec_tick = 1; reg_wr = 1; reg_addr = 8'h44; reg_wdata = 32'h80; reg_wstrb = 4'h1;
    @(negedge clk);
    sec_tick = 0; reg_wr = 0; reg_wstrb = '0;
    rd(8'h44, rdv); check("R8 set wins", rdv, 32'h80);
    wr(8'h44, 32'h80, 4'h1);
    // R9 enable write while flag held
    wr(8'h48, 32'h0, 4'hF);
    tick();
    check("R9 irq off with ien 0", {31'b0, irq_o}, 32'h0);
    wr(8'h48, 32'h10, 4'hF);
    check("R9 irq same edge as enable", {31'b0, irq_o}, 32'h1);
    wr(8'h44, 32'h80, 4'h1);

    // R3 / R10 power-off
    wr(8'h98, 32'h0001_0000, 4'h4);
    rd(8'h98, rdv); check("R3 pctl", rdv, 32'h0001_0000);
    time_now = 48'h25_02_28_07_45_00;
    tick();
    check("R10 no match no off", {31'b0, pwr_en_o}, 32'h1);
    time_now = 48'h25_02_28_07_45_01;
    tick();
    check("R10 pwr off", {31'b0, pwr_en_o}, 32'h0);
    wr(8'h98, 32'h0, 4'hF);
    wr(8'h44, 32'h80, 4'h1);
    tick(); wr(8'h44, 32'h80, 4'h1);
    repeat (4) @(negedge clk);
    check("R10 sticky", {31'b0, pwr_en_o}, 32'h0);

    // R1 reset restores power
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 pwr after reset", {31'b0, pwr_en_o}, 32'h1);
    rd(8'h98, rdv); check("R1 pctl after reset", rdv, 32'h0);
    finish_run();
  end
endmodule